// File: doc/BRIEF.md
# Preemptive Cache Bank Request Arbiter

This block controls one bank of a last-level cache whose write operations are much slower than its reads. Four request classes compete for the bank. From most to least critical they are demand read, demand fill, prefetch fill and write-back. Each class has its own valid/ready port. The arbiter gives the idle bank to the most critical pending request. It then holds the bank busy for that operation's latency, using a cycle counter in place of the storage array.

Operations do not always run to completion. A pending request of strictly higher priority may cut short an operation that is in flight, but only while the elapsed share of that operation is below a per-class completion threshold, given as a percentage. The victim gets a one-cycle abort pulse on its own port and must present its request again. In the shared-top mode, read and fill form one priority level: they alternate round-robin and neither can preempt the other.

Top module: `bank_req_arbiter`

## Requirements
- R1: During and right after a synchronous active-high reset, the bank is idle, the elapsed count is 0, and no ready or abort pulse is driven.
- R2: With shared-top mode off, class codes 0 read, 1 fill, 2 prefetch fill and 3 write-back are granted strictly in that order when they are pending together.
- R3: A read occupies the bank for RD_LAT (default 12) cycles. The elapsed count is 0 in the cycle of its ready pulse and rises by one each cycle after that.
- R4: Fill, prefetch fill and write-back occupy the bank for 20, 48 or 128 cycles when `cfg_wr_lat` is 0, 1 or 2. Code 3 also selects 128.
- R5: When a pending request is on a strictly higher level and elapsed×100 < threshold×latency for the operation in flight (defaults: fill 25, prefetch fill 60, write-back 100), the in-flight class gets a one-cycle abort pulse with the bank idle in that same cycle. The winner's ready pulse follows one cycle later.
- R6: Once elapsed×100 ≥ threshold×latency, the operation is not aborted and runs to its full latency. The higher request is granted in the second cycle after the bank goes idle.
- R7: A class with a 100% threshold can be preempted up to and including its last busy cycle.
- R8: With shared-top mode on, read and fill form one level and never preempt each other. When both are pending at an idle bank, grants alternate between them, starting with read after reset.
- R9: Each grant is a single ready pulse on one port only. It is issued only in the cycle after an idle cycle, so a grant never comes straight out of a busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shared_top | input | 1 | 1: read and fill share the top priority level |
| cfg_wr_lat | input | 2 | Write latency select: 0=20, 1=48, 2/3=128 cycles |
| req_valid | input | 4 | Request valid per class (bit 0 read … bit 3 write-back) |
| req_ready | output | 4 | One-cycle grant pulse per class |
| req_abort | output | 4 | One-cycle preemption pulse per class |
| bank_busy | output | 1 | Bank occupied by an operation |
| bank_class | output | 2 | Class of the current or last operation |
| bank_elapsed | output | CNT_W | Cycles elapsed in the current operation |

## Verification
The assertions assume that a requester keeps valid high until it sees its ready pulse, drops it right after, and raises it again only to replay after an abort. They also assume the configuration inputs change only while reset is held. The stimulus keeps to this with one driver routine. That routine clears a class's valid bit at the sample point where its ready pulse shows, and it changes the mode and latency select only inside its reset routine. Preempting requests are raised at chosen elapsed values, so that each threshold is tested on both sides of its integer boundary.

// File: rtl/bra_pkg.sv
package bra_pkg;
  localparam int NCLS  = 4;
  localparam int PCT_W = 7;

  typedef enum logic [1:0] {
    CLS_RD    = 2'd0,
    CLS_FILL  = 2'd1,
    CLS_PFILL = 2'd2,
    CLS_WB    = 2'd3
  } req_cls_e;

  // Priority level of a class; smaller is more critical.
  function automatic logic [1:0] cls_level(input logic [1:0] cls, input logic shared);
    if (shared && cls != 2'd0) return cls - 2'd1;
    return cls;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/bra_lat_sel.sv
module bra_lat_sel #(
  parameter int RD_LAT   = 12,
  parameter int WR_LAT_A = 20,
  parameter int WR_LAT_B = 48,
  parameter int WR_LAT_C = 128,
  parameter int CNT_W    = 8
) (
  input  logic [1:0]       cls,
  input  logic [1:0]       wr_sel,
  output logic [CNT_W-1:0] lat
);
  always_comb begin
    if (cls == bra_pkg::CLS_RD) begin
      lat = CNT_W'(RD_LAT);
    end else begin
      case (wr_sel)
        2'd0:    lat = CNT_W'(WR_LAT_A);
        2'd1:    lat = CNT_W'(WR_LAT_B);
        default: lat = CNT_W'(WR_LAT_C);
      endcase
    end
  end
endmodule

// File: rtl/bra_pick.sv
module bra_pick (
  input  logic [3:0] valid,
  input  logic       shared,
  input  logic       fill_first,
  output logic       any,
  output logic [1:0] win
);
  always_comb begin
    any = |valid;
    win = 2'd0;
    if (shared && valid[0] && valid[1]) begin
      win = fill_first ? 2'd1 : 2'd0;
    end else begin
      for (int c = 3; c >= 0; c--) begin
        if (valid[c]) win = 2'(c);
      end
    end
  end
endmodule

// File: rtl/bra_preempt.sv
module bra_preempt #(
  parameter int                  CNT_W   = 8,
  parameter int                  PCT_W   = 7,
  parameter logic [4*PCT_W-1:0]  THR_VEC = '0
) (
  input  logic             busy,
  input  logic             shared,
  input  logic [3:0]       valid,
  input  logic [1:0]       cur,
  input  logic [CNT_W-1:0] elapsed,
  input  logic [CNT_W-1:0] total,
  output logic             preempt
);
  localparam int PW = CNT_W + PCT_W;

  logic [3:0]       higher;
  logic [PCT_W-1:0] thr;
  logic [PW-1:0]    done_scaled;
  logic [PW-1:0]    limit_scaled;

  for (genvar c = 0; c < 4; c++) begin : g_hi
    assign higher[c] = valid[c] &&
      (bra_pkg::cls_level(2'(c), shared) < bra_pkg::cls_level(cur, shared));
  end

  assign thr          = THR_VEC[cur*PCT_W +: PCT_W];
  assign done_scaled  = PW'(elapsed) * PW'(100);
  assign limit_scaled = PW'(thr) * PW'(total);
  assign preempt      = busy && (|higher) && (done_scaled < limit_scaled);
endmodule

// File: rtl/bank_req_arbiter.sv
module bank_req_arbiter #(
  parameter int                  RD_LAT    = 12,
  parameter int                  WR_LAT_A  = 20,
  parameter int                  WR_LAT_B  = 48,
  parameter int                  WR_LAT_C  = 128,
  parameter logic [bra_pkg::PCT_W-1:0] THR_FILL  = 7'd25,
  parameter logic [bra_pkg::PCT_W-1:0] THR_PFILL = 7'd60,
  parameter logic [bra_pkg::PCT_W-1:0] THR_WB    = 7'd100,
  localparam int CNT_W = $clog2(bra_pkg::max_of(bra_pkg::max_of(RD_LAT, WR_LAT_A),
                                 bra_pkg::max_of(WR_LAT_B, WR_LAT_C)) + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_shared_top,
  input  logic [1:0]       cfg_wr_lat,
  input  logic [3:0]       req_valid,
  output logic [3:0]       req_ready,
  output logic [3:0]       req_abort,
  output logic             bank_busy,
  output logic [1:0]       bank_class,
  output logic [CNT_W-1:0] bank_elapsed
);
  localparam int PCT_W = bra_pkg::PCT_W;
  localparam logic [4*PCT_W-1:0] THR_VEC = {THR_WB, THR_PFILL, THR_FILL, {PCT_W{1'b0}}};

  logic             any_req;
  logic [1:0]       win;
  logic [CNT_W-1:0] win_lat;
  logic [CNT_W-1:0] total_q;
  logic             fill_first_q;
  logic             preempt;

  bra_pick u_pick (
    .valid      (req_valid),
    .shared     (cfg_shared_top),
    .fill_first (fill_first_q),
    .any        (any_req),
    .win        (win)
  );

  bra_lat_sel #(
    .RD_LAT(RD_LAT), .WR_LAT_A(WR_LAT_A), .WR_LAT_B(WR_LAT_B),
    .WR_LAT_C(WR_LAT_C), .CNT_W(CNT_W)
  ) u_lat (
    .cls    (win),
    .wr_sel (cfg_wr_lat),
    .lat    (win_lat)
  );

  bra_preempt #(.CNT_W(CNT_W), .PCT_W(PCT_W), .THR_VEC(THR_VEC)) u_pre (
    .busy    (bank_busy),
    .shared  (cfg_shared_top),
    .valid   (req_valid),
    .cur     (bank_class),
    .elapsed (bank_elapsed),
    .total   (total_q),
    .preempt (preempt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_busy    <= 1'b0;
      bank_class   <= 2'd0;
      bank_elapsed <= '0;
      total_q      <= '0;
      fill_first_q <= 1'b0;
      req_ready    <= '0;
      req_abort    <= '0;
    end else begin
      req_ready <= '0;
      req_abort <= '0;
      if (!bank_busy) begin
        if (any_req) begin
          bank_busy       <= 1'b1;
          bank_class      <= win;
          bank_elapsed    <= '0;
          total_q         <= win_lat;
          req_ready[win]  <= 1'b1;
          if (win == 2'd0) fill_first_q <= 1'b1;
          if (win == 2'd1) fill_first_q <= 1'b0;
        end
      end else if (preempt) begin
        bank_busy             <= 1'b0;
        bank_elapsed          <= '0;
        req_abort[bank_class] <= 1'b1;
      end else if (bank_elapsed == total_q - CNT_W'(1)) begin
        bank_busy    <= 1'b0;
        bank_elapsed <= '0;
      end else begin
        bank_elapsed <= bank_elapsed + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/bra_chk.sv
module bra_chk #(
  parameter int RD_LAT = 12,
  parameter int CNT_W  = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_shared_top,
  input logic [3:0]       req_ready,
  input logic [3:0]       req_abort,
  input logic             bank_busy,
  input logic [1:0]       bank_class,
  input logic [CNT_W-1:0] bank_elapsed
);
  AST_READY_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_ready)); // R9

  AST_READY_AFTER_IDLE: assert property (@(posedge clk) disable iff (rst)
    (|req_ready) |-> (bank_busy && bank_elapsed == '0 && !$past(bank_busy))); // R9

  AST_ABORT_OWN_CLASS: assert property (@(posedge clk) disable iff (rst)
    (|req_abort) |-> (!bank_busy && $past(bank_busy) && req_abort == (4'b0001 << bank_class))); // R5

  AST_READ_NEVER_ABORTED: assert property (@(posedge clk) disable iff (rst)
    !req_abort[0]); // R5

  AST_SHARED_FILL_KEPT: assert property (@(posedge clk) disable iff (rst)
    cfg_shared_top |-> !req_abort[1]); // R8

  AST_ELAPSED_STEP: assert property (@(posedge clk) disable iff (rst)
    (bank_busy && $past(bank_busy) && !(|req_ready)) |-> (bank_elapsed == $past(bank_elapsed) + CNT_W'(1))); // R3

  AST_READ_LENGTH: assert property (@(posedge clk) disable iff (rst)
    ($fell(bank_busy) && !(|req_abort) && bank_class == 2'd0) |-> ($past(bank_elapsed) == CNT_W'(RD_LAT - 1))); // R3

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (!bank_busy && req_ready == '0 && req_abort == '0)); // R1
endmodule

bind bank_req_arbiter bra_chk #(.RD_LAT(RD_LAT), .CNT_W(CNT_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .cfg_shared_top (cfg_shared_top),
  .req_ready      (req_ready),
  .req_abort      (req_abort),
  .bank_busy      (bank_busy),
  .bank_class     (bank_class),
  .bank_elapsed   (bank_elapsed)
);

// File: tb/bank_req_arbiter_tb.sv
`timescale 1ns/1ps
module bank_req_arbiter_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       shared = 1'b0;
  logic [1:0] wsel = 2'd0;
  logic [3:0] valid = 4'h0;
  logic [3:0] ready, abort;
  logic       busy;
  logic [1:0] bcls;
  logic [7:0] elapsed;

  always #2 clk = ~clk;

  bank_req_arbiter u_dut (
    .clk(clk), .rst(rst), .cfg_shared_top(shared), .cfg_wr_lat(wsel),
    .req_valid(valid), .req_ready(ready), .req_abort(abort),
    .bank_busy(busy), .bank_class(bcls), .bank_elapsed(elapsed)
  );

  typedef struct { bit ab; int c; } ev_t;
  ev_t expq[$];
  int  n_chk = 0, n_fail = 0, n_abort = 0;
  bit  ended = 0;

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic expect_ev(input bit ab, input int c);
    ev_t e; e.ab = ab; e.c = c; expq.push_back(e);
  endtask

  task automatic mon_evt(input bit ab, input int c);
    ev_t e;
    if (expq.size() == 0) chk(0, "R9 unexpected event", ab*10 + c, -1);
    else begin
      e = expq.pop_front();
      chk(e.ab == ab && e.c == c, "R2/R5 event order", ab*10 + c, e.ab*10 + e.c);
    end
  endtask

  // Monitor: pops the scoreboard on every ready/abort pulse.
  always @(negedge clk) begin
    if (!rst) begin
      for (int c = 0; c < 4; c++) begin
        if (ready[c]) mon_evt(0, c);
        if (abort[c]) begin n_abort++; mon_evt(1, c); end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    for (int c = 0; c < 4; c++) if (ready[c]) valid[c] = 1'b0;
  endtask

  task automatic do_reset(input bit sh, input logic [1:0] ws);
    rst = 1'b1; shared = sh; wsel = ws; valid = 4'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wait_grant(input int c);
    int t = 0;
    while (!ready[c] && t < 500) begin tick(); t++; end
    chk(ready[c], "R9 grant pulse seen", ready[c], 1);
  endtask

  task automatic run_len(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; tick(); end
  endtask

  task automatic until_elapsed(input int k);
    int t = 0;
    while (elapsed != 8'(k) && t < 500) begin tick(); t++; end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int n, na;
    // R1: reset state
    do_reset(0, 2'd0);
    @(negedge clk);
    chk(!busy && ready == 0 && abort == 0 && elapsed == 0, "R1 reset idle", busy, 0);

    // R3: read occupancy
    do_reset(0, 2'd0);
    expect_ev(0, 0); valid[0] = 1'b1;
    wait_grant(0);
    chk(elapsed == 0, "R3 elapsed at grant", elapsed, 0);
    run_len(n);
    chk(n == 12, "R3 read busy cycles", n, 12);

    // R4: write latencies per select code
    for (int ws = 0; ws < 4; ws++) begin
      int expn;
      expn = (ws == 0) ? 20 : (ws == 1) ? 48 : 128;
      do_reset(0, 2'(ws));
      expect_ev(0, 3); valid[3] = 1'b1;
      wait_grant(3);
      run_len(n);
      chk(n == expn, "R4 write busy cycles", n, expn);
    end

    // R2: strict order with all four pending; R9 idle gap
    do_reset(0, 2'd0);
    expect_ev(0, 0); expect_ev(0, 1); expect_ev(0, 2); expect_ev(0, 3);
    valid = 4'hF;
    wait_grant(0);
    run_len(n);
    chk(!busy && ready == 0, "R9 idle cycle before next grant", ready, 0);
    tick();
    chk(ready[1], "R2 fill after read", ready, 2);
    n = 0;
    while ((valid != 0 || busy) && n < 2000) begin tick(); n++; end

    // R5: prefetch fill preempted early
    do_reset(0, 2'd0);
    expect_ev(0, 2); valid[2] = 1'b1;
    wait_grant(2);
    until_elapsed(5);
    expect_ev(1, 2); expect_ev(0, 0); valid[0] = 1'b1;
    tick();
    chk(abort[2] && !busy, "R5 abort pulse, bank idle", abort, 4);
    tick();
    chk(ready[0], "R5 read granted after abort", ready, 1);
    run_len(n);

    // R5/R6 boundary: threshold 60% of 20 -> elapsed 11 aborts, 12 does not
    do_reset(0, 2'd0);
    expect_ev(0, 2); valid[2] = 1'b1;
    wait_grant(2);
    until_elapsed(11);
    expect_ev(1, 2); expect_ev(0, 0); valid[0] = 1'b1;
    tick();
    chk(abort[2], "R5 abort at elapsed 11", abort, 4);
    tick(); run_len(n);

    do_reset(0, 2'd0);
    expect_ev(0, 2); valid[2] = 1'b1;
    wait_grant(2);
    until_elapsed(12);
    expect_ev(0, 0); valid[0] = 1'b1;
    na = n_abort;
    run_len(n);
    chk(n == 8, "R6 runs to completion", n, 8);
    chk(n_abort == na, "R6 no abort past threshold", n_abort - na, 0);
    tick();
    chk(ready[0], "R6 read granted after completion", ready, 1);
    run_len(n);

    // R7: 100% threshold, preempted on last busy cycle
    do_reset(0, 2'd0);
    expect_ev(0, 3); valid[3] = 1'b1;
    wait_grant(3);
    until_elapsed(19);
    expect_ev(1, 3); expect_ev(0, 0); valid[0] = 1'b1;
    tick();
    chk(abort[3], "R7 write-back aborted at last cycle", abort, 8);
    tick();
    chk(ready[0], "R7 read granted", ready, 1);
    run_len(n);

    // R5: strict mode, read preempts fill (25% of 20 -> below 5)
    do_reset(0, 2'd0);
    expect_ev(0, 1); valid[1] = 1'b1;
    wait_grant(1);
    until_elapsed(1);
    expect_ev(1, 1); expect_ev(0, 0); valid[0] = 1'b1;
    tick();
    chk(abort[1], "R5 fill aborted by read", abort, 2);
    tick(); run_len(n);

    // R8: shared mode, read does not preempt fill
    do_reset(1, 2'd0);
    expect_ev(0, 1); valid[1] = 1'b1;
    wait_grant(1);
    until_elapsed(1);
    expect_ev(0, 0); valid[0] = 1'b1;
    na = n_abort;
    run_len(n);
    chk(n == 19 && n_abort == na, "R8 fill not preempted in shared mode", n, 19);
    tick();
    chk(ready[0], "R8 read after fill", ready, 1);
    run_len(n);

    // R8: round-robin read/fill in shared mode: read, fill, read
    do_reset(1, 2'd0);
    expect_ev(0, 0); expect_ev(0, 1); expect_ev(0, 0);
    valid[0] = 1'b1; valid[1] = 1'b1;
    wait_grant(0);
    valid[0] = 1'b1;
    run_len(n);
    tick();
    chk(ready[1], "R8 fill wins second round", ready, 2);
    run_len(n);
    tick();
    chk(ready[0], "R8 read wins third round", ready, 1);
    run_len(n);

    tick();
    chk(expq.size() == 0, "R9 all expected events observed", expq.size(), 0);
    summary();
  end
endmodule